// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation that the TLB could not supply. When `start_i` is pulsed, it captures the 32-bit virtual address, the privilege level and the kind of access. It computes where the matching page table entry sits in memory and issues one read on a plain request/response port. When the entry comes back, the block decides whether the access succeeds, fails because the page is absent, or fails because of its permissions.

A successful walk returns the 30-bit physical address and the entry to be written into the TLB. Any fault returns zeros for both. The 12-bit page offset is carried straight through. The table is flat and indexed by the 20-bit virtual page number, with 4-byte entries placed from a base address.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after its release, `done_o`, `mem_req_o` and `busy_o` are 0.
- R2: In the cycle after an accepted start, `mem_req_o` is 1 for exactly one cycle, and `mem_addr_o` equals `ptbr_i + 4 * vaddr_i[31:12]`, with both inputs sampled at the start.
- R3: `done_o` is 1 for exactly one cycle, namely the cycle after the one in which `mem_resp_valid_i` is seen while waiting. It comes `delay + 1` cycles after the request cycle, where `delay` (at least 1) is the number of cycles from the request to the response.
- R4: An entry whose bit 31 (present) is 0 gives `fault_o` = 01 (page fault), with `paddr_o` and `tlb_entry_o` equal to 0. This holds whatever the other entry bits are.
- R5: A present entry that grants the access gives `fault_o` = 00, `paddr_o` = {entry[17:0], vaddr[11:0]} and `tlb_entry_o` = entry.
- R6: The rights in entry bits 30:28 are 001 read-only, 011 read-write and 100 execute-only; all other codes grant nothing. `acc_i` is 00 load, 01 store, 10 fetch and 11 unsupported. A load needs 001 or 011, a store needs 011 and a fetch needs 100. Otherwise `fault_o` = 10 (protection fault) with zero outputs.
- R7: Entry bit 27 marks a page as kernel-only. With `kernel_i` = 0 such a page gives `fault_o` = 10. With `kernel_i` = 1 the bit is ignored and R6 still applies.
- R8: `start_i` has no effect while a walk is in progress (from the cycle after the start up to and including the done cycle). Only one memory request is made, and the result belongs to the first start.
- R9: `busy_o` is 1 from the cycle after an accepted start through the done cycle, and 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (TLB miss) |
| vaddr_i | input | 32 | Virtual address to translate |
| ptbr_i | input | 32 | Page table base address |
| kernel_i | input | 1 | 1 = kernel privilege, 0 = user |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Entry address of the request |
| mem_resp_valid_i | input | 1 | Read data valid |
| mem_resp_data_i | input | 32 | Page table entry read |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| paddr_o | output | 30 | Translated physical address |
| tlb_entry_o | output | 32 | Entry for the TLB fill |

## Verification
A corrupted state register shows up at the ports within a cycle or two:
- A walk that never leaves the waiting state leaves `busy_o` stuck high with no `done_o`.
- A state that loops back to the request state produces a second `mem_req_o`.
- Latched request attributes that are wrong appear at completion, either as a wrong offset in `paddr_o` or as a fault code that disagrees with the entry returned.

Because of this, every walk checks the request address, the exact completion cycle, the single request and all three outputs against values computed from the entry the bench returned.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_NONE  = 2'b11
    } access_e;

    localparam int PTE_W      = 32;
    localparam int PTE_VALID  = 31;
    localparam int PTE_RW_HI  = 30;
    localparam int PTE_RW_LO  = 28;
    localparam int PTE_KONLY  = 27;

    localparam logic [2:0] RIGHTS_RO = 3'b001;
    localparam logic [2:0] RIGHTS_RW = 3'b011;
    localparam logic [2:0] RIGHTS_XO = 3'b100;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VPN_W-1:0]  vpn_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - VPN_W;

    logic [ADDR_W-1:0] index_scaled;

    generate
        if (PAD_W > 0) begin : g_pad
            assign index_scaled = {{PAD_W{1'b0}}, vpn_i} << ENTRY_SHIFT;
        end else begin : g_nopad
            assign index_scaled = vpn_i[ADDR_W-1:0] << ENTRY_SHIFT;
        end
    endgenerate

    assign addr_o = base_i + index_scaled;
endmodule

// File: rtl/pt_rights_check.sv
module pt_rights_check
    import pt_walker_pkg::*;
(
    input  logic [PTE_W-1:0] pte_i,
    input  logic             kernel_i,
    input  logic [1:0]       acc_i,
    output logic [1:0]       fault_o
);
    logic [2:0] rights;
    logic       granted;

    assign rights = pte_i[PTE_RW_HI:PTE_RW_LO];

    always_comb begin
        unique case (acc_i)
            ACC_LOAD:  granted = (rights == RIGHTS_RO) || (rights == RIGHTS_RW);
            ACC_STORE: granted = (rights == RIGHTS_RW);
            ACC_FETCH: granted = (rights == RIGHTS_XO);
            default:   granted = 1'b0;
        endcase
    end

    always_comb begin
        if (!pte_i[PTE_VALID]) begin
            fault_o = FLT_PAGE;
        end else if (pte_i[PTE_KONLY] && !kernel_i) begin
            fault_o = FLT_PROT;
        end else if (!granted) begin
            fault_o = FLT_PROT;
        end else begin
            fault_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 30,
    parameter int OFF_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [ADDR_W-1:0] ptbr_i,
    input  logic              kernel_i,
    input  logic [1:0]        acc_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_resp_valid_i,
    input  logic [31:0]       mem_resp_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        fault_o,
    output logic [PA_W-1:0]   paddr_o,
    output logic [31:0]       tlb_entry_o
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        walk_state_e       st;
        logic [OFF_W-1:0]  offset;
        logic              kern;
        logic [1:0]        acc;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        fault;
        logic [PA_W-1:0]   paddr;
        logic [PTE_W-1:0]  entry;
    } walk_regs_t;

    walk_regs_t s_d, s_q;

    logic [ADDR_W-1:0] entry_addr_d;
    logic [1:0]        check_fault_d;

    pt_entry_addr #(
        .ADDR_W      (ADDR_W),
        .VPN_W       (VPN_W),
        .ENTRY_SHIFT (2)
    ) i_entry_addr (
        .base_i (ptbr_i),
        .vpn_i  (vaddr_i[VA_W-1:OFF_W]),
        .addr_o (entry_addr_d)
    );

    pt_rights_check i_rights_check (
        .pte_i    (mem_resp_data_i),
        .kernel_i (s_q.kern),
        .acc_i    (s_q.acc),
        .fault_o  (check_fault_d)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.offset = vaddr_i[OFF_W-1:0];
                    s_d.kern   = kernel_i;
                    s_d.acc    = acc_i;
                    s_d.addr   = entry_addr_d;
                    s_d.st     = ST_REQ;
                end
            end
            ST_REQ: begin
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_resp_valid_i) begin
                    s_d.fault = check_fault_d;
                    if (check_fault_d == FLT_NONE) begin
                        s_d.paddr = {mem_resp_data_i[PPN_W-1:0], s_q.offset};
                        s_d.entry = mem_resp_data_i;
                    end else begin
                        s_d.paddr = '0;
                        s_d.entry = '0;
                    end
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_o   = (s_q.st == ST_REQ);
    assign mem_addr_o  = s_q.addr;
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = (s_q.st == ST_DONE);
    assign fault_o     = s_q.fault;
    assign paddr_o     = s_q.paddr;
    assign tlb_entry_o = s_q.entry;
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        mem_req_o,
    input logic        mem_resp_valid_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [1:0]  fault_o,
    input logic [29:0] paddr_o,
    input logic [31:0] tlb_entry_o
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R2
    AST_REQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ($past(start_i) && !$past(busy_o))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_resp_valid_i)); // R3
    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != 2'b00) |-> (paddr_o == '0 && tlb_entry_o == '0)); // R4
    AST_OK_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 2'b00) |-> (tlb_entry_o[31] && paddr_o[29:12] == tlb_entry_o[17:0])); // R5
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_o != 2'b11)); // R6
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R9
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R9
endmodule

bind pt_walker pt_walker_checker i_pt_walker_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .mem_req_o        (mem_req_o),
    .mem_resp_valid_i (mem_resp_valid_i),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .fault_o          (fault_o),
    .paddr_o          (paddr_o),
    .tlb_entry_o      (tlb_entry_o)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [31:0] ptbr_i = '0;
    logic        kernel_i = 1'b0;
    logic [1:0]  acc_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_resp_valid_i = 1'b0;
    logic [31:0] mem_resp_data_i = '0;
    logic        busy_o, done_o;
    logic [1:0]  fault_o;
    logic [29:0] paddr_o;
    logic [31:0] tlb_entry_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int req_count = 0;
    int resp_delay = 1;
    logic [31:0] table_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .ptbr_i(ptbr_i), .kernel_i(kernel_i), .acc_i(acc_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_resp_valid_i(mem_resp_valid_i), .mem_resp_data_i(mem_resp_data_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
        .paddr_o(paddr_o), .tlb_entry_o(tlb_entry_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic kern,
                                             input logic [1:0] acc);
        logic [2:0] r;
        logic ok;
        r = pte[30:28];
        case (acc)
            2'b00:   ok = (r == 3'b001) || (r == 3'b011);
            2'b01:   ok = (r == 3'b011);
            2'b10:   ok = (r == 3'b100);
            default: ok = 1'b0;
        endcase
        if (!pte[31]) return 2'b01;
        if (pte[27] && !kern) return 2'b10;
        return ok ? 2'b00 : 2'b10;
    endfunction

    // Memory model: answers each request after resp_delay cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                logic [31:0] a;
                a = mem_addr_o;
                req_count++;
                repeat (resp_delay) @(negedge clk);
                mem_resp_valid_i = 1'b1;
                mem_resp_data_i  = table_mem[a[7:2]];
                @(negedge clk);
                mem_resp_valid_i = 1'b0;
                mem_resp_data_i  = $urandom;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic kern,
                        input logic [1:0] acc, input logic [31:0] pte, input int dly,
                        input bit stray_start);
        logic [1:0] ef;
        int n;
        table_mem[va[17:12]] = pte;
        resp_delay = dly;
        req_count  = 0;
        ef = exp_fault(pte, kern, acc);
        @(negedge clk);
        start_i = 1'b1; vaddr_i = va; ptbr_i = base; kernel_i = kern; acc_i = acc;
        @(negedge clk);
        start_i = stray_start;
        if (stray_start) begin
            vaddr_i = ~va; ptbr_i = base + 32'h100; acc_i = ~acc; kernel_i = ~kern;
        end
        check("R2 req", {63'd0, mem_req_o}, 64'd1);
        check("R2 addr", {32'd0, mem_addr_o}, {32'd0, base + {va[31:12], 2'b00}});
        check("R9 busy", {63'd0, busy_o}, 64'd1);
        n = 1;
        while (!done_o && n < 60) begin
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check("R3 done cycle", 64'(n), 64'(dly + 2));
        check("R9 busy at done", {63'd0, busy_o}, 64'd1);
        if (ef == 2'b01)      check("R4 fault", {62'd0, fault_o}, {62'd0, ef});
        else if (pte[27] && !kern) check("R7 fault", {62'd0, fault_o}, {62'd0, ef});
        else                  check("R6 fault", {62'd0, fault_o}, {62'd0, ef});
        if (ef == 2'b00) begin
            check("R5 paddr", {34'd0, paddr_o}, {34'd0, pte[17:0], va[11:0]});
            check("R5 entry", {32'd0, tlb_entry_o}, {32'd0, pte});
        end else begin
            check("R4 paddr zero", {34'd0, paddr_o}, 64'd0);
            check("R4 entry zero", {32'd0, tlb_entry_o}, 64'd0);
        end
        if (stray_start) check("R8 one request", 64'(req_count), 64'd1);
        @(negedge clk);
        check("R3 done single", {63'd0, done_o}, 64'd0);
        check("R9 idle", {63'd0, busy_o}, 64'd0);
        if (stray_start) check("R8 no second req", {63'd0, mem_req_o}, 64'd0);
    endtask

    function automatic logic [31:0] mk_pte(input logic v, input logic [2:0] r,
                                           input logic k, input logic [17:0] ppn);
        return {v, r, k, 9'd0, ppn};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A1B));
        for (int i = 0; i < 64; i++) table_mem[i] = '0;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset done", {63'd0, done_o}, 64'd0);
            check("R1 reset req", {63'd0, mem_req_o}, 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle busy", {63'd0, busy_o}, 64'd0);
        check("R1 idle done", {63'd0, done_o}, 64'd0);

        // Directed corners
        walk(32'h0001_2ABC, 32'h1000_0000, 1'b0, 2'b00, mk_pte(1, 3'b001, 0, 18'h2_1234), 1, 0); // R5 load RO
        walk(32'h0003_4FFF, 32'h2000_0000, 1'b0, 2'b01, mk_pte(1, 3'b001, 0, 18'h0_0042), 2, 0); // R6 store to RO
        walk(32'h0005_6000, 32'h2000_0000, 1'b0, 2'b01, mk_pte(1, 3'b011, 0, 18'h3_FFFF), 3, 0); // R5 store RW
        walk(32'h0007_8123, 32'h3000_0000, 1'b0, 2'b10, mk_pte(1, 3'b100, 0, 18'h1_0101), 1, 0); // R6 fetch XO
        walk(32'h0007_8123, 32'h3000_0000, 1'b0, 2'b00, mk_pte(1, 3'b100, 0, 18'h1_0101), 1, 0); // R6 load XO
        walk(32'h0009_A456, 32'h3000_0000, 1'b1, 2'b11, mk_pte(1, 3'b011, 0, 18'h0_1111), 2, 0); // R6 acc 11
        walk(32'hFFFF_F789, 32'h4000_0000, 1'b1, 2'b00, mk_pte(0, 3'b011, 0, 18'h2_2222), 4, 0); // R4 absent
        walk(32'h000B_C001, 32'h4000_0000, 1'b0, 2'b00, mk_pte(1, 3'b011, 1, 18'h0_5555), 1, 0); // R7 user
        walk(32'h000B_C001, 32'h4000_0000, 1'b1, 2'b00, mk_pte(1, 3'b011, 1, 18'h0_5555), 1, 0); // R7 kernel
        walk(32'h000D_E002, 32'h4000_0000, 1'b1, 2'b01, mk_pte(1, 3'b001, 1, 18'h0_6666), 2, 0); // R7 kernel, R6 deny
        walk(32'h000F_0ABC, 32'h5000_0000, 1'b0, 2'b00, mk_pte(1, 3'b011, 0, 18'h1_2345), 5, 1); // R8 stray start

        // Constrained random walks
        for (int i = 0; i < 200; i++) begin
            logic [31:0] va, base, pte;
            va   = $urandom;
            base = {$urandom_range(0, 32'h00FF_FFFF), 8'h00};
            pte  = mk_pte(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                          ($urandom_range(0, 3) == 0), 18'($urandom));
            pte[26:18] = 9'($urandom);
            walk(va, base, 1'($urandom), 2'($urandom), pte,
                 $urandom_range(1, 6), ($urandom_range(0, 4) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule